// File: doc/BRIEF.md
# Ping-Pong I/Q Packet Buffer

This block turns a slow stream of complex baseband samples into fixed-size byte payloads for a simple frame transmitter. Each I/Q pair has two 16-bit halves. It is split into four bytes, so the pair rate becomes a byte rate four times higher. The bytes are written into one of two on-chip byte memories.

When the memory being filled receives its last byte, the two memories swap roles. The full one is then offered to the transmitter through a request line. The transmitter fetches the payload through a byte-address read port and frees the memory with a done pulse. Meanwhile, the other memory keeps collecting samples.

After reset, the block spends a programmable number of packets in a warm-up phase. During warm-up it offers only one full buffer in every four and discards the rest. This leaves idle gaps on the line in which the physical layer can send its link pulses, so the far end can detect a 10 Mbit link. After warm-up, every full buffer is offered.

Top module: `iq_pkt_buffer`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_req`, `overflow` and `tx_data` are all zero.
- R2: Pair k of a payload (k counted from 0) is stored at byte addresses 4k to 4k+3, in the order I bits 15:8, I bits 7:0, Q bits 15:8, Q bits 7:0. Pairs must arrive at least 4 cycles apart.
- R3: If the filling memory completes while `tx_req` is high and `tx_done` is low, `overflow` is set and stays set until reset. The filling memory then restarts at address 0, overwriting its contents, and those pairs are never offered. The pending request is unaffected.
- R4: A payload holds exactly 256 pairs (1024 bytes). `tx_req` rises on the cycle after the last byte of an offered payload is written.
- R5: `tx_data` presents the byte at the address on `tx_addr` one clock after that address is sampled.
- R6: `tx_req` stays high until `tx_done` is seen, and falls on the cycle after `tx_done`.
- R7: Full memories are counted from 0 after reset. While that count is below `warmup_pkts`, only counts that are multiples of 4 are offered. The other full memories are swapped and discarded.
- R8: Once `warmup_pkts` full memories have completed, every full memory is offered.
- R9: The two memories alternate, so the payloads offered back to back after warm-up carry consecutive runs of pairs with no gap. The memory being read is never the one being written.
- R10: With `warmup_pkts` at 0 there is no warm-up phase, and the first two payloads after reset are both offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | One-cycle strobe marking a new I/Q pair |
| iq_i | input | 16 | In-phase sample |
| iq_q | input | 16 | Quadrature sample |
| warmup_pkts | input | 16 | Number of full memories in the warm-up phase |
| tx_req | output | 1 | A full payload is ready to be read |
| tx_addr | input | 10 | Byte address of the read |
| tx_data | output | 8 | Read byte, one clock after the address |
| tx_done | input | 1 | One-cycle pulse that frees the offered memory |
| overflow | output | 1 | Sticky flag: a payload was lost because the transmitter was late |

## Verification
On every cycle, the assertions check the following:
- the request/done handshake holds and releases correctly;
- the overflow flag never clears without reset;
- an overflow is only raised while a request is pending;
- the memory being read is never the memory being filled.

Some behaviours can only be shown by the directed scenarios, which compare whole payloads of a counting pattern against expected pair numbers:
- the byte order within each payload;
- which full memories are skipped during warm-up;
- the seamless hand-off between the two memories;
- the fact that a payload lost to overflow never reaches the transmitter.

// File: rtl/iq_pkt_pkg.sv
`timescale 1ns/1ps
package iq_pkt_pkg;

    // One byte leaving the pair serializer
    typedef struct packed {
        logic       vld;
        logic [7:0] dat;
    } beat_t;

    // Outcome of a completed fill
    typedef enum logic [1:0] {
        FILL_NONE    = 2'd0,
        FILL_OFFER   = 2'd1,
        FILL_DISCARD = 2'd2,
        FILL_LOST    = 2'd3
    } fill_kind_e;

    // Decide whether the full memory with this index is offered
    function automatic logic offer_this(input int unsigned idx,
                                        input int unsigned limit,
                                        input int unsigned ratio);
        return (idx >= limit) || ((idx % ratio) == 0);
    endfunction

endpackage

// File: rtl/iq_byte_serializer.sv
`timescale 1ns/1ps
module iq_byte_serializer
    import iq_pkt_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output beat_t               beat
);
    localparam int NB = (2 * SAMPLE_W) / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [2*SAMPLE_W-1:0] hold;
    logic [IW-1:0]         idx;
    logic                  busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            idx  <= '0;
            busy <= 1'b0;
            beat <= '0;
        end else begin
            beat.vld <= 1'b0;
            if (!busy && in_vld) begin
                hold     <= {in_i, in_q};
                beat.vld <= 1'b1;
                beat.dat <= in_i[SAMPLE_W-1 -: 8];
                idx      <= IW'(1);
                busy     <= 1'b1;
            end else if (busy) begin
                beat.vld <= 1'b1;
                beat.dat <= hold[(NB-1-int'(idx))*8 +: 8];
                idx      <= idx + IW'(1);
                if (idx == IW'(NB-1)) begin
                    busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iq_pingpong_mem.sv
`timescale 1ns/1ps
module iq_pingpong_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(b))) begin
                store[wr_addr] <= wr_data;
            end
        end

        assign bank_q[b] = store[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_sel ? bank_q[1] : bank_q[0];
        end
    end
endmodule

// File: rtl/iq_swap_ctrl.sv
`timescale 1ns/1ps
module iq_swap_ctrl
    import iq_pkt_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int AW         = $clog2(DEPTH),
    parameter int CW         = 16,
    parameter int SKIP_RATIO = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_vld,
    input  logic [CW-1:0] warmup_pkts,
    input  logic          tx_done,
    output logic [AW-1:0] wr_addr,
    output logic          fill_sel,
    output logic          tx_sel,
    output logic          tx_req,
    output logic          overflow
);
    logic [CW-1:0] pkt_cnt;
    logic          last_beat;
    logic          reader_busy;
    fill_kind_e    kind;

    always_comb begin
        last_beat   = beat_vld && (wr_addr == AW'(DEPTH-1));
        reader_busy = tx_req && !tx_done;
        kind        = FILL_NONE;
        if (last_beat) begin
            if (reader_busy) begin
                kind = FILL_LOST;
            end else if (offer_this(32'(pkt_cnt), 32'(warmup_pkts), SKIP_RATIO)) begin
                kind = FILL_OFFER;
            end else begin
                kind = FILL_DISCARD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr  <= '0;
            fill_sel <= 1'b0;
            tx_sel   <= 1'b0;
            tx_req   <= 1'b0;
            overflow <= 1'b0;
            pkt_cnt  <= '0;
        end else begin
            if (beat_vld) begin
                wr_addr <= last_beat ? '0 : wr_addr + AW'(1);
            end
            if (tx_req && tx_done) begin
                tx_req <= 1'b0;
            end
            case (kind)
                FILL_LOST: overflow <= 1'b1;
                FILL_OFFER, FILL_DISCARD: begin
                    fill_sel <= ~fill_sel;
                    if (kind == FILL_OFFER) begin
                        tx_req <= 1'b1;
                        tx_sel <= fill_sel;
                    end
                    if (pkt_cnt < warmup_pkts) begin
                        pkt_cnt <= pkt_cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iq_pkt_buffer.sv
`timescale 1ns/1ps
module iq_pkt_buffer
    import iq_pkt_pkg::*;
#(
    parameter int SAMPLE_W      = 16,
    parameter int PAYLOAD_BYTES = 1024,
    parameter int CNT_W         = 16,
    parameter int SKIP_RATIO    = 4,
    localparam int AW           = $clog2(PAYLOAD_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                iq_valid,
    input  logic [SAMPLE_W-1:0] iq_i,
    input  logic [SAMPLE_W-1:0] iq_q,
    input  logic [CNT_W-1:0]    warmup_pkts,
    output logic                tx_req,
    input  logic [AW-1:0]       tx_addr,
    output logic [7:0]          tx_data,
    input  logic                tx_done,
    output logic                overflow
);
    beat_t         beat;
    logic [AW-1:0] wr_addr;
    logic          fill_sel;
    logic          tx_sel;

    iq_byte_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .in_vld (iq_valid),
        .in_i   (iq_i),
        .in_q   (iq_q),
        .beat   (beat)
    );

    iq_swap_ctrl #(
        .DEPTH      (PAYLOAD_BYTES),
        .AW         (AW),
        .CW         (CNT_W),
        .SKIP_RATIO (SKIP_RATIO)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .beat_vld    (beat.vld),
        .warmup_pkts (warmup_pkts),
        .tx_done     (tx_done),
        .wr_addr     (wr_addr),
        .fill_sel    (fill_sel),
        .tx_sel      (tx_sel),
        .tx_req      (tx_req),
        .overflow    (overflow)
    );

    iq_pingpong_mem #(.DEPTH(PAYLOAD_BYTES), .AW(AW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (beat.vld),
        .wr_sel  (fill_sel),
        .wr_addr (wr_addr),
        .wr_data (beat.dat),
        .rd_sel  (tx_sel),
        .rd_addr (tx_addr),
        .rd_data (tx_data)
    );
endmodule

// File: rtl/iq_pkt_buffer_chk.sv
`timescale 1ns/1ps
module iq_pkt_buffer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_req,
    input logic       tx_done,
    input logic       overflow,
    input logic [7:0] tx_data,
    input logic       fill_sel,
    input logic       tx_sel
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_req && !overflow && tx_data == 8'd0));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(tx_req) && !$past(tx_done)));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done) |=> tx_req);

    p_req_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_req) |-> $past(tx_done));

    p_no_shared_bank_r9: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (fill_sel != tx_sel));
endmodule

bind iq_pkt_buffer iq_pkt_buffer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_req   (tx_req),
    .tx_done  (tx_done),
    .overflow (overflow),
    .tx_data  (tx_data),
    .fill_sel (fill_sel),
    .tx_sel   (tx_sel)
);

// File: tb/sim_iq_pkt_buffer.sv
`timescale 1ns/1ps
module sim_iq_pkt_buffer;
    localparam int NBYTES = 1024;
    localparam int NPAIRS = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iq_valid = 1'b0;
    logic [15:0] iq_i = '0;
    logic [15:0] iq_q = '0;
    logic [15:0] warmup = 16'd8;
    logic [9:0]  tx_addr = '0;
    logic        tx_done = 1'b0;
    logic        tx_req;
    logic [7:0]  tx_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int pair_n = 0;
    int phase = 0;
    int req_rises = 0;
    logic req_d = 1'b0;
    logic feed_en = 1'b0;

    iq_pkt_buffer u0 (
        .clk         (clk),
        .rst         (rst),
        .iq_valid    (iq_valid),
        .iq_i        (iq_i),
        .iq_q        (iq_q),
        .warmup_pkts (warmup),
        .tx_req      (tx_req),
        .tx_addr     (tx_addr),
        .tx_data     (tx_data),
        .tx_done     (tx_done),
        .overflow    (overflow)
    );

    initial forever #2.5 clk = ~clk;

    // Counting-pattern source: one pair every 8 cycles
    initial forever begin
        @(negedge clk);
        if (rst || !feed_en) begin
            iq_valid = 1'b0;
            pair_n   = 0;
            phase    = 0;
        end else begin
            if (phase == 0) begin
                iq_valid = 1'b1;
                iq_i     = 16'(pair_n);
                iq_q     = 16'(pair_n) ^ 16'hA5A5;
                pair_n++;
            end else begin
                iq_valid = 1'b0;
            end
            phase = (phase + 1) % 8;
        end
    end

    // Request edge counter
    initial forever begin
        @(negedge clk);
        if (rst) req_rises = 0;
        else if (tx_req && !req_d) req_rises++;
        req_d = tx_req;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int p, input int k);
        logic [15:0] vi, vq;
        vi = 16'(p);
        vq = 16'(p) ^ 16'hA5A5;
        case (k)
            0: return vi[15:8];
            1: return vi[7:0];
            2: return vq[15:8];
            default: return vq[7:0];
        endcase
    endfunction

    // Wait for a request, read the whole payload, compare, release
    task automatic serve(input int first_pair, input string req);
        int waited = 0;
        int bad = 0;
        int bad_act = 0;
        int bad_exp = 0;
        while (!tx_req && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(tx_req == 1'b1, {req, " request seen"}, int'(tx_req), 1);
        tx_addr = '0;
        for (int a = 1; a <= NBYTES; a++) begin
            @(negedge clk);
            if (a == 1) begin
                check(tx_data == exp_byte(first_pair, 0), "R5 first byte one clock after address",
                      int'(tx_data), int'(exp_byte(first_pair, 0)));
            end
            if (tx_data != exp_byte(first_pair + (a-1)/4, (a-1)%4)) begin
                if (bad == 0) begin
                    bad_act = int'(tx_data);
                    bad_exp = int'(exp_byte(first_pair + (a-1)/4, (a-1)%4));
                end
                bad++;
            end
            if (a < NBYTES) tx_addr = 10'(a);
        end
        check(bad == 0, {req, " R2 R4 payload bytes"}, bad_act, bad_exp);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check(tx_req == 1'b0, "R6 request released after done", int'(tx_req), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        feed_en = 1'b0;
        repeat (5) @(negedge clk);
        check(tx_req == 1'b0, "R1 tx_req in reset", int'(tx_req), 0);
        check(overflow == 1'b0, "R1 overflow in reset", int'(overflow), 0);
        check(tx_data == 8'd0, "R1 tx_data in reset", int'(tx_data), 0);
        rst = 1'b0;
        feed_en = 1'b1;
    endtask

    task automatic t_warmup();
        serve(0, "R7 packet 0");
        serve(4 * NPAIRS, "R7 packet 4");
        check(req_rises == 2, "R7 only every fourth offered", req_rises, 2);
        serve(8 * NPAIRS, "R8 packet 8");
        serve(9 * NPAIRS, "R9 packet 9");
        serve(10 * NPAIRS, "R8 packet 10");
        check(req_rises == 5, "R8 every packet after warm-up", req_rises, 5);
        check(overflow == 1'b0, "R3 no overflow when served in time", int'(overflow), 0);
    endtask

    task automatic t_overflow();
        int waited = 0;
        while (!overflow && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(overflow == 1'b1, "R3 overflow when reader late", int'(overflow), 1);
        check(tx_req == 1'b1, "R3 pending request kept", int'(tx_req), 1);
        serve(11 * NPAIRS, "R3 pending payload intact");
        serve(13 * NPAIRS, "R3 lost payload skipped");
        check(overflow == 1'b1, "R3 overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_no_warmup();
        warmup = 16'd0;
        t_reset();
        serve(0, "R10 packet 0");
        serve(NPAIRS, "R10 packet 1");
        check(req_rises == 2, "R10 both offered", req_rises, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_warmup();
        t_overflow();
        t_no_warmup();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule